// File: doc/BRIEF.md
# Self-Checking Carry-Select Adder

This block adds two 64-bit operands and a carry-in in a single combinational pass. It also detects, at the same time, any single internal fault that would corrupt the result. The operands are split into eight 8-bit slices.

Inside each slice, two ripple chains run side by side: one assumes the slice's carry-in is 0 and the other assumes it is 1. The carry chosen for the previous slice picks which chain's result is used. The first slice takes the external carry-in directly.

Every slice builds its sum twice:
- a true rail, derived from the propagate signals;
- an inverted rail, derived from independently formed equivalence signals.

A parity comparison cross-checks the propagate signals. The parity of both operands, XORed together, must equal the XOR of all propagate bits.

All rail pairs and the parity pair are merged by a tree of two-rail checker cells into one two-rail error indicator. A fault-free adder always shows a valid code word on that indicator, and a detected fault shows a non-code word. A test-only port can force a stuck value onto any single propagate bit, true-rail bit or inverted-rail bit.

Top module: `sc_csel_adder`

## Requirements
- R1: With injection off, `{cout,sum}` equals `a + b + cin` as a 65-bit unsigned value.
- R2: Carries cross every 8-bit slice boundary, including a carry rippling through all 64 positions (`a` all ones, `b` zero, `cin`=1 gives `sum`=0, `cout`=1).
- R3: With injection off, `err` is a valid code word: `01` or `10`.
- R4: Site codes 0 to 63 select the propagate bit of the same index. Forcing it to the complement of `a[i]^b[i]` drives `err` to `00` or `11`.
- R5: Site codes 64 to 127 select true-rail sum bit (code−64). Forcing it to the complement of its correct value drives `err` to `00` or `11`, and `sum` shows the forced bit.
- R6: Site codes 128 to 191 select inverted-rail bit (code−128). Forcing it to the value of the correct sum bit drives `err` to `00` or `11`, and `sum` stays correct.
- R7: Forcing a site to the value it already carries has no effect: `sum`/`cout` stay correct and `err` stays valid.
- R8: Site codes 192 to 255 with injection on have no effect on `sum`, `cout` or `err` validity.
- R9: With `flt_en`=0, `flt_site` and `flt_val` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| flt_en | input | 1 | Test only: enables the stuck-value injection |
| flt_site | input | 8 | Test only: injection site code (see R4 to R6, R8) |
| flt_val | input | 1 | Test only: value forced at the site |
| sum | output | 64 | Sum, taken from the true rail |
| cout | output | 1 | Carry out of bit 63 |
| err | output | 2 | Two-rail error indicator; 01/10 means fault-free, 00/11 means error |

## Verification
The block holds no state, so every output is due in the same cycle its inputs are applied. No register sits between an operand or fault setting and `sum`, `cout` or `err`. The bench changes inputs just after a rising clock edge and samples at the following falling edge, half a period later, so the logic has settled and no edge ordering matters. Fault checks choose the forced value from the operands, so each injection either truly flips its site (R4 to R6) or provably leaves it unchanged (R7).

// File: rtl/sc_csel_adder.sv
module sc_csel_adder #(
  parameter int W = 64,
  parameter int B = 8,
  localparam int NB = W / B,
  localparam int SW = $clog2(4 * W),
  localparam int NP = 2 * W,
  localparam int LV = $clog2(NP)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  input  logic          flt_en,
  input  logic [SW-1:0] flt_site,
  input  logic          flt_val,
  output logic [W-1:0]  sum,
  output logic          cout,
  output logic [1:0]    err
);

  logic [W-1:0] m_p, m_t, m_n;
  logic [W-1:0] p, pn, g;
  logic [W-1:0] r0, r1, n0, n1, st, sn, st_f, sn_f;
  logic [NB-1:0] co0, co1;
  logic [NB:0] bc;
  logic [1:0] tr [NP];

  always_comb begin
    int s;
    s = int'(flt_site);
    m_p = '0;
    m_t = '0;
    m_n = '0;
    if (flt_en) begin
      if (s < W) m_p[s % W] = 1'b1;
      else if (s < 2 * W) m_t[s % W] = 1'b1;
      else if (s < 3 * W) m_n[s % W] = 1'b1;
    end
  end

  assign g  = a & b;
  assign p  = ((a ^ b) & ~m_p) | ({W{flt_val}} & m_p);
  assign pn = (a & b) | (~a & ~b);

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      logic c0, c1;
      c0 = 1'b0;
      c1 = 1'b1;
      for (int j = 0; j < B; j++) begin
        r0[k*B+j] = p[k*B+j] ^ c0;
        r1[k*B+j] = p[k*B+j] ^ c1;
        n0[k*B+j] = pn[k*B+j] ^ c0;
        n1[k*B+j] = pn[k*B+j] ^ c1;
        c0 = g[k*B+j] | (p[k*B+j] & c0);
        c1 = g[k*B+j] | (p[k*B+j] & c1);
      end
      co0[k] = c0;
      co1[k] = c1;
    end
  end

  assign bc[0] = cin;
  for (genvar k = 0; k < NB; k++) begin : g_sel
    assign bc[k+1]        = bc[k] ? co1[k] : co0[k];
    assign st[k*B +: B]   = bc[k] ? r1[k*B +: B] : r0[k*B +: B];
    assign sn[k*B +: B]   = bc[k] ? n1[k*B +: B] : n0[k*B +: B];
  end

  assign st_f = (st & ~m_t) | ({W{flt_val}} & m_t);
  assign sn_f = (sn & ~m_n) | ({W{flt_val}} & m_n);
  assign sum  = st_f;
  assign cout = bc[NB];

  always_comb begin
    for (int i = 0; i < NP; i++) tr[i] = 2'b01;
    for (int i = 0; i < W; i++) tr[i] = {st_f[i], sn_f[i]};
    tr[W] = {^a ^ ^b, ~(^p)};
    for (int l = 0; l < LV; l++) begin
      for (int i = 0; i < NP / 2; i++) begin
        if (i < (NP >> (l + 1))) begin
          tr[i] = {(tr[2*i][1] & tr[2*i+1][1]) | (tr[2*i][0] & tr[2*i+1][0]),
                   (tr[2*i][1] & tr[2*i+1][0]) | (tr[2*i][0] & tr[2*i+1][1])};
        end
      end
    end
    err = tr[0];
  end

  always_comb begin
    if (!flt_en) begin
      a_r1_sum_exact: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
      a_r3_err_code: assert (err[1] != err[0]);
    end
    if (flt_en && int'(flt_site) >= 3 * W) begin
      a_r8_site_inert: assert (err[1] != err[0]);
    end
    if (flt_en && int'(flt_site) < W) begin
      if (flt_val != (a[int'(flt_site) % W] ^ b[int'(flt_site) % W])) begin
        a_r4_prop_flag: assert (err[1] == err[0]);
      end
    end
  end

endmodule

// File: tb/sim_sc_csel_adder.sv
module sim_sc_csel_adder;
  localparam int W = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic cin, flt_en, flt_val, cout;
  logic [7:0] flt_site;
  logic [1:0] err;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  sc_csel_adder u0 (.a(a), .b(b), .cin(cin), .flt_en(flt_en), .flt_site(flt_site),
                    .flt_val(flt_val), .sum(sum), .cout(cout), .err(err));

  typedef struct packed { logic [W-1:0] a, b; logic ci; logic [W-1:0] s; logic co; } vec_t;
  localparam vec_t VT [6] = '{
    '{64'h0, 64'h0, 1'b0, 64'h0, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 64'h0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    '{64'h0000_0000_0000_00FF, 64'h1, 1'b0, 64'h0000_0000_0000_0100, 1'b0},
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 64'h0, 1'b1},
    '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, 64'h0, 1'b1}
  };

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_code(input string req, input bit want_valid);
    n_chk++;
    if ((err[1] != err[0]) !== want_valid) begin
      n_bad++;
      $display("FAIL %s actual err=%b expected %s", req, err, want_valid ? "01/10" : "00/11");
    end
  endtask

  task automatic apply(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic ic,
                       input logic fe, input logic [7:0] fs, input logic fv);
    @(posedge clk);
    #1;
    a = ia; b = ib; cin = ic; flt_en = fe; flt_site = fs; flt_val = fv;
    @(negedge clk);
  endtask

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    logic [W:0] ex;
    a = '0; b = '0; cin = 1'b0; flt_en = 1'b0; flt_site = '0; flt_val = 1'b0;

    // R3 quiet-input state
    apply('0, '0, 1'b0, 1'b0, 8'd0, 1'b0);
    chk("R1 zero inputs", {cout, sum}, '0);
    chk_code("R3 zero inputs", 1'b1);

    // R1 R2 table
    foreach (VT[i]) begin
      apply(VT[i].a, VT[i].b, VT[i].ci, 1'b0, 8'd0, 1'b0);
      chk("R1 R2 table", {cout, sum}, {VT[i].co, VT[i].s});
      chk_code("R3 table", 1'b1);
    end

    // R1 R3 random
    for (int i = 0; i < 200; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      apply(ra, rb, 1'(i), 1'b0, 8'd0, 1'b0);
      chk("R1 random", {cout, sum}, ref_add(ra, rb, 1'(i)));
      chk_code("R3 random", 1'b1);
    end

    // R9 ignored site/value while disabled
    ra = 64'hDEAD_BEEF_0BAD_F00D;
    rb = 64'h1357_9BDF_2468_ACE0;
    for (int s = 0; s < 256; s += 37) begin
      apply(ra, rb, 1'b1, 1'b0, 8'(s), 1'(s));
      chk("R9 disabled injection", {cout, sum}, ref_add(ra, rb, 1'b1));
      chk_code("R9 disabled injection", 1'b1);
    end

    // R4 R5 R6 R7 single faults at every site
    for (int s = 0; s < 192; s++) begin
      int bi;
      logic cv;
      bi = s % W;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      ex = ref_add(ra, rb, 1'b0);
      if (s < W) cv = ra[bi] ^ rb[bi];
      else if (s < 2 * W) cv = ex[bi];
      else cv = ~ex[bi];
      apply(ra, rb, 1'b0, 1'b1, 8'(s), ~cv);
      if (s < W) chk_code("R4 propagate fault", 1'b0);
      else if (s < 2 * W) begin
        chk_code("R5 true-rail fault", 1'b0);
        chk("R5 forced sum bit", {1'b0, sum[bi]}, {{W{1'b0}}, ~cv});
      end else begin
        chk_code("R6 inverted-rail fault", 1'b0);
        chk("R6 sum unaffected", {cout, sum}, ex);
      end
      apply(ra, rb, 1'b0, 1'b1, 8'(s), cv);
      chk("R7 benign stuck value", {cout, sum}, ex);
      chk_code("R7 benign stuck value", 1'b1);
    end

    // R8 out-of-range site codes
    for (int s = 192; s < 256; s += 9) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      apply(ra, rb, 1'b1, 1'b1, 8'(s), 1'(s));
      chk("R8 unused site", {cout, sum}, ref_add(ra, rb, 1'b1));
      chk_code("R8 unused site", 1'b1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule